// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the control state machine of a battery-free nonvolatile SRAM. It decides when the whole SRAM image is copied into the nonvolatile array (a store) and when the array is copied back into the SRAM (a recall). It fires single-cycle start strobes at the bulk-copy engines and gates the SRAM port with separate read and write inhibits. It also drives the pull-down of a shared open-drain store/busy line. That line is both an input and an output. Another agent requests a store by pulling the line low. The block holds the line low while a store is pending or running.

The block takes a digital low-voltage flag, a power-good flag and a strap that disables automatic stores. It also takes the synchronised level of the busy line and a strobe for each SRAM write. A dirty flag remembers whether any write has landed since the last store or recall, and clean stores are skipped. A low-voltage event in automatic mode triggers a store powered from the holdup capacitor, then waits for power to return and recalls the image. Every duration is a parameter counted in clock cycles.

Top module: `nv_backup_ctrl`

## Requirements
- R1: After reset, and after any low-voltage event, the block waits with reads and writes inhibited and `idle` low. When `pwr_good` is high and `low_volt` is low, it pulses `recall_go` and keeps access inhibited for RECALL_CYC cycles. It then enters idle with `idle` high and both inhibits low.
- R2: Any SRAM write accepted while `wr_inhibit` is low sets a dirty flag. A completed store clears the flag, and so does a completed recall.
- R3: In idle, if `busy_pin` is low and the block's own pull-down did not cause it, and the dirty flag is set, the block asserts `busy_pull` and waits GRACE_CYC cycles before pulsing `store_go`. Reads stay allowed during that wait.
- R4: An external request on `busy_pin` while the dirty flag is clear starts no store and asserts no `busy_pull`.
- R5: While `busy_pin` is held low from outside, `wr_inhibit` is high and write strobes are not accepted.
- R6: `busy_pull` stays high for the whole store, which lasts STORE_CYC cycles starting with the `store_go` cycle.
- R7: After a store started by an external request, the block releases `busy_pull` and keeps reads and writes inhibited until `busy_pin` is seen high again. It then returns to idle.
- R8: With `auto_off` low, `low_volt` seen in idle raises `busy_pull` on the next clock edge. If the dirty flag is set, a store follows. After the store the block waits for power to return, then recalls.
- R9: On such an automatic trigger with the dirty flag clear, `busy_pull` is a pulse exactly PULSE_CYC cycles long, and no store follows.
- R10: If `busy_pin` is still sensed high at the end of the automatic trigger pulse, the block releases the line and abandons the store.
- R11: With `auto_off` high, `low_volt` never raises `busy_pull` and starts no store. Stores then come only from requests on `busy_pin`.
- R12: A request that arrives while a store or recall is running is dropped, not queued. One store produces exactly one `store_go`.
- R13: `store_go` and `recall_go` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| low_volt | input | 1 | Supply has fallen below the store trigger level |
| pwr_good | input | 1 | Supply has recovered and a recall may start |
| auto_off | input | 1 | Strap: no automatic store on power loss |
| busy_pin | input | 1 | Raw level of the open-drain store/busy line |
| sram_wr | input | 1 | One-cycle strobe for an SRAM write |
| busy_pull | output | 1 | Enable for the pull-down on the store/busy line |
| store_go | output | 1 | One-cycle start of a bulk store |
| recall_go | output | 1 | One-cycle start of a bulk recall |
| wr_inhibit | output | 1 | Blocks SRAM writes |
| rd_inhibit | output | 1 | Blocks SRAM reads |
| idle | output | 1 | Block is idle and normal access is allowed |

## Verification
The hardest case to reach is the aborted automatic store. The block must be pulling the shared line low while it senses the line high, which cannot happen with a plain wired-AND pin model. The bench therefore models the line as the AND of both pull-downs, plus an override that forces it high as if a strong driver held it. It then raises `low_volt` after a write, so the dirty path is the one that gets abandoned. A second corner is the low-voltage flag arriving in the middle of a requested store. The bench raises it between `store_go` and the store's end and checks that only one store and no recall result.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [2:0] {
    ST_DOWN,    // supply low or after reset: recall pending
    ST_RECALL,  // array to SRAM copy running
    ST_IDLE,    // normal SRAM access
    ST_SENSE,   // automatic trigger pulse on the busy line
    ST_GRACE,   // pending SRAM cycles drain before a store
    ST_STORE,   // SRAM to array copy running
    ST_LOCK     // store done, waiting for the line to rise
  } nvb_state_e;
endpackage

// File: rtl/nvb_sync.sv
module nvb_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R6: an unloaded running count steps down by one each cycle
  a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/nv_backup_ctrl.sv
module nv_backup_ctrl #(
  parameter int unsigned GRACE_CYC   = 125,
  parameter int unsigned STORE_CYC   = 1250000,
  parameter int unsigned RECALL_CYC  = 68750,
  parameter int unsigned PULSE_CYC   = 125,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic low_volt,
  input  logic pwr_good,
  input  logic auto_off,
  input  logic busy_pin,
  input  logic sram_wr,
  output logic busy_pull,
  output logic store_go,
  output logic recall_go,
  output logic wr_inhibit,
  output logic rd_inhibit,
  output logic idle
);
  import nvb_pkg::*;

  localparam int unsigned MAX_AB = (GRACE_CYC > STORE_CYC) ? GRACE_CYC : STORE_CYC;
  localparam int unsigned MAX_CD = (RECALL_CYC > PULSE_CYC) ? RECALL_CYC : PULSE_CYC;
  localparam int unsigned MAX_D  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned TW     = $clog2(MAX_D + 1);

  nvb_state_e    state_q, state_n;
  logic          pin_s, pull_s, ext_req, wr_ok;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          dirty_q, auto_q;

  // line level and own pull-down, delayed through identical stages
  nvb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst(rst), .d(busy_pin), .q(pin_s));
  nvb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pull_sync (
    .clk(clk), .rst(rst), .d(busy_pull), .q(pull_s));

  assign ext_req = !pin_s && !pull_s;
  assign wr_ok   = sram_wr && !wr_inhibit;

  nvb_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done));

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_DOWN:   if (pwr_good && !low_volt) state_n = ST_RECALL;
      ST_RECALL: if (tmr_done) state_n = ST_IDLE;
      ST_IDLE: begin
        if (low_volt)                state_n = auto_off ? ST_DOWN : ST_SENSE;
        else if (ext_req && dirty_q) state_n = ST_GRACE;
      end
      ST_SENSE: if (tmr_done) state_n = (!dirty_q || pin_s) ? ST_DOWN : ST_GRACE;
      ST_GRACE: if (tmr_done) state_n = ST_STORE;
      ST_STORE: if (tmr_done) state_n = auto_q ? ST_DOWN : ST_LOCK;
      ST_LOCK:  if (pin_s) state_n = ST_IDLE;
      default:  state_n = ST_DOWN;
    endcase
  end

  assign tmr_load = (state_n != state_q);

  always_comb begin
    unique case (state_n)
      ST_RECALL: tmr_val = TW'(RECALL_CYC - 1);
      ST_SENSE:  tmr_val = TW'(PULSE_CYC - 1);
      ST_GRACE:  tmr_val = TW'(GRACE_CYC - 1);
      ST_STORE:  tmr_val = TW'(STORE_CYC - 1);
      default:   tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_DOWN;
      dirty_q    <= 1'b0;
      auto_q     <= 1'b0;
      busy_pull  <= 1'b0;
      store_go   <= 1'b0;
      recall_go  <= 1'b0;
      wr_inhibit <= 1'b1;
      rd_inhibit <= 1'b1;
      idle       <= 1'b0;
    end else begin
      state_q <= state_n;
      if ((state_q == ST_STORE || state_q == ST_RECALL) && tmr_done) dirty_q <= 1'b0;
      else if (wr_ok)                                                 dirty_q <= 1'b1;
      if (state_q == ST_IDLE && state_n == ST_SENSE)      auto_q <= 1'b1;
      else if (state_q == ST_IDLE && state_n == ST_GRACE) auto_q <= 1'b0;
      busy_pull  <= (state_n == ST_SENSE) || (state_n == ST_GRACE) || (state_n == ST_STORE);
      store_go   <= (state_n == ST_STORE)  && (state_q != ST_STORE);
      recall_go  <= (state_n == ST_RECALL) && (state_q != ST_RECALL);
      rd_inhibit <= (state_n == ST_DOWN) || (state_n == ST_RECALL) ||
                    (state_n == ST_STORE) || (state_n == ST_LOCK);
      wr_inhibit <= (state_n != ST_IDLE) || ext_req;
      idle       <= (state_n == ST_IDLE);
    end
  end

  // R13: start strobes are exclusive and one cycle wide
  a_r13_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(store_go && recall_go));
  a_r13_store_single: assert property (@(posedge clk) disable iff (rst)
    store_go |=> !store_go);
  // R4: a store only ever starts with unsaved writes present
  a_r4_store_needs_dirty: assert property (@(posedge clk) disable iff (rst)
    store_go |-> dirty_q);
  // R6: the line is pulled for the whole store
  a_r6_pull_in_store: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STORE) |-> busy_pull);
  // R7: lock blocks access and releases the line
  a_r7_lock_blocks: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCK) |-> (rd_inhibit && wr_inhibit && !busy_pull));
  // R8: automatic trigger pulls the line at the next edge
  a_r8_fast_pull: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && low_volt && !auto_off) |=> busy_pull);
  // R11: with the strap set, power loss neither pulls nor stores
  a_r11_no_auto: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && low_volt && auto_off) |=> (!busy_pull && !store_go));
  // R2: an accepted write marks the image dirty
  a_r2_dirty_set: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> dirty_q);
endmodule

// File: tb/nv_backup_ctrl_bench.sv
module nv_backup_ctrl_bench;
  localparam int unsigned G = 4;
  localparam int unsigned S = 10;
  localparam int unsigned R = 6;
  localparam int unsigned P = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic low_volt = 1'b0, pwr_good = 1'b0, auto_off = 1'b0, sram_wr = 1'b0;
  logic ext_low = 1'b0, force_high = 1'b0;
  logic busy_pin;
  logic busy_pull, store_go, recall_go, wr_inhibit, rd_inhibit, idle;

  int total = 0, fails = 0;
  int n_store = 0, n_recall = 0, n_overlap = 0, n_double = 0;
  int cyc_count = 0;
  logic prev_store = 1'b0;

  always #4 clk = ~clk;

  assign busy_pin = force_high | ~(busy_pull | ext_low);

  nv_backup_ctrl #(.GRACE_CYC(G), .STORE_CYC(S), .RECALL_CYC(R), .PULSE_CYC(P)) u_nv_backup_ctrl (
    .clk(clk), .rst(rst), .low_volt(low_volt), .pwr_good(pwr_good), .auto_off(auto_off),
    .busy_pin(busy_pin), .sram_wr(sram_wr), .busy_pull(busy_pull), .store_go(store_go),
    .recall_go(recall_go), .wr_inhibit(wr_inhibit), .rd_inhibit(rd_inhibit), .idle(idle));

  always @(posedge clk) begin
    cyc_count++;
    if (!rst) begin
      if (store_go) n_store++;
      if (recall_go) n_recall++;
      if (store_go && recall_go) n_overlap++;
      if (store_go && prev_store) n_double++;
    end
    prev_store = store_go;
    if (cyc_count > 20000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc_count);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // wait for a chosen output to reach a value; returns cycles waited, -1 on timeout
  task automatic wait_sig(input int which, input bit val, input int maxc, output int cyc);
    bit v;
    cyc = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      case (which)
        0: v = idle;
        1: v = busy_pull;
        2: v = store_go;
        default: v = recall_go;
      endcase
      if (v == val) begin cyc = i; break; end
    end
  endtask

  task automatic do_write();
    sram_wr = 1'b1; tick(1); sram_wr = 1'b0;
  endtask

  task automatic t_reset();
    tick(3); rst = 1'b0; tick(3);
    check(idle == 0, "R1", "idle while recall pending", idle, 0);
    check(rd_inhibit == 1 && wr_inhibit == 1, "R1", "access blocked before power good", rd_inhibit, 1);
    check(n_recall == 0, "R1", "no recall without power good", n_recall, 0);
  endtask

  task automatic t_recall();
    int c;
    pwr_good = 1'b1;
    wait_sig(3, 1, 10, c);
    check(c > 0, "R1", "recall strobe seen", c, 1);
    check(rd_inhibit == 1, "R1", "reads blocked during recall", rd_inhibit, 1);
    wait_sig(0, 1, 20, c);
    check(c == R, "R1", "recall length", c, R);
    check(rd_inhibit == 0 && wr_inhibit == 0, "R1", "access open in idle", wr_inhibit, 0);
  endtask

  task automatic t_clean_req();
    int s0 = n_store, pulls = 0;
    ext_low = 1'b1; tick(3);
    check(wr_inhibit == 1, "R5", "writes blocked while line held low", wr_inhibit, 1);
    do_write();
    for (int i = 0; i < 10; i++) begin tick(1); if (busy_pull) pulls++; end
    check(n_store == s0 && pulls == 0, "R4", "clean request starts nothing", n_store - s0 + pulls, 0);
    ext_low = 1'b0; tick(5);
    ext_low = 1'b1; tick(15);
    check(n_store == s0, "R5", "blocked write left image clean", n_store - s0, 0);
    ext_low = 1'b0; tick(5);
    check(idle == 1, "R4", "idle after clean request", idle, 1);
  endtask

  task automatic t_ext_store();
    int c, s0 = n_store, pulled = 0;
    do_write();
    ext_low = 1'b1;
    tick(4);
    check(busy_pull == 1 && rd_inhibit == 0, "R3", "grace pulls line, reads allowed", rd_inhibit, 0);
    wait_sig(2, 1, 20, c);
    check(c == G - 1, "R3", "store start after grace", c + 4, G + 3);
    for (int i = 0; i < 30; i++) begin
      if (busy_pull) pulled++; else break;
      tick(1);
    end
    check(pulled == S, "R6", "store length with line pulled", pulled, S);
    tick(5);
    check(rd_inhibit && wr_inhibit && !idle, "R7", "locked while line low", idle, 0);
    ext_low = 1'b0;
    wait_sig(0, 1, 8, c);
    check(c > 0, "R7", "idle after line rises", c, 1);
    ext_low = 1'b1; tick(12); ext_low = 1'b0; tick(5);
    check(n_store == s0 + 1, "R2", "store cleared dirty flag", n_store - s0, 1);
  endtask

  task automatic t_reentry();
    int c, s0 = n_store, r0 = n_recall;
    do_write();
    ext_low = 1'b1;
    wait_sig(2, 1, 20, c);
    tick(2); low_volt = 1'b1; tick(3); low_volt = 1'b0;
    wait_sig(1, 0, 30, c);
    ext_low = 1'b0;
    wait_sig(0, 1, 10, c);
    check(n_store == s0 + 1 && n_recall == r0, "R12", "request during store dropped",
          n_store - s0 + n_recall - r0, 1);
  endtask

  task automatic t_auto_store();
    int c, s0 = n_store, r0 = n_recall;
    do_write();
    low_volt = 1'b1; tick(1);
    check(busy_pull == 1, "R8", "pull one edge after low voltage", busy_pull, 1);
    wait_sig(2, 1, 30, c);
    check(c > 0, "R8", "automatic store started", c, 1);
    wait_sig(1, 0, 30, c);
    tick(2);
    check(rd_inhibit == 1 && idle == 0, "R8", "waits for power after store", idle, 0);
    low_volt = 1'b0;
    wait_sig(0, 1, 30, c);
    check(n_store == s0 + 1 && n_recall == r0 + 1, "R8", "store then recall", n_recall - r0, 1);
  endtask

  task automatic t_auto_clean();
    int c, s0 = n_store, pulls = 0;
    low_volt = 1'b1;
    for (int i = 0; i < 30; i++) begin tick(1); if (busy_pull) pulls++; end
    check(pulls == P, "R9", "clean trigger pulse width", pulls, P);
    check(n_store == s0, "R9", "no store when clean", n_store - s0, 0);
    low_volt = 1'b0;
    wait_sig(0, 1, 30, c);
  endtask

  task automatic t_abort();
    int c, s0 = n_store, pulls = 0;
    do_write();
    force_high = 1'b1; low_volt = 1'b1;
    for (int i = 0; i < 30; i++) begin tick(1); if (busy_pull) pulls++; end
    check(n_store == s0, "R10", "store abandoned when line stays high", n_store - s0, 0);
    check(pulls == P, "R10", "line released after trigger pulse", pulls, P);
    force_high = 1'b0; low_volt = 1'b0;
    wait_sig(0, 1, 30, c);
  endtask

  task automatic t_inhibit();
    int c, s0 = n_store, pulls = 0;
    auto_off = 1'b1;
    do_write();
    low_volt = 1'b1;
    for (int i = 0; i < 10; i++) begin tick(1); if (busy_pull) pulls++; end
    check(pulls == 0 && n_store == s0, "R11", "no automatic pull or store", pulls, 0);
    check(rd_inhibit == 1, "R11", "still waits for recall", rd_inhibit, 1);
    low_volt = 1'b0;
    wait_sig(0, 1, 30, c);
    do_write();
    ext_low = 1'b1;
    wait_sig(2, 1, 20, c);
    check(c > 0, "R11", "pin request still stores", c, 1);
    wait_sig(1, 0, 30, c);
    ext_low = 1'b0;
    wait_sig(0, 1, 10, c);
    auto_off = 1'b0;
  endtask

  initial begin
    t_reset();
    t_recall();
    t_clean_req();
    t_ext_store();
    t_reentry();
    t_auto_store();
    t_auto_clean();
    t_abort();
    t_inhibit();
    check(n_overlap == 0, "R13", "strobes never together", n_overlap, 0);
    check(n_double == 0, "R13", "store strobe one cycle", n_double, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule